// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters that all advance on the same clock. Software reaches it through four byte-wide ports selected by a 2-bit address. Offsets 0, 1 and 2 are the data ports of counters 0, 1 and 2. Offset 3 takes control words. A control word picks one counter and sets four things for it: how its 16-bit count is moved through the 8-bit port, its operating mode, and whether it counts in binary or in packed BCD. The same port also accepts a snapshot command, which freezes a counter's present value so it can be read without stopping the count.

Each counter drives one output pin. There are three behaviours. The first is a terminal-count flag that rises once and stays high. The second is a rate generator with a one-clock low pulse per period. The third is a square wave with its high half first. Counters cannot be chained. A typical use is a periodic tick: program a rate divisor into one counter and wire its pin to an interrupt line. For example, a 1,193,182 Hz input clock divided by 0xFFFF gives roughly 18.2 ticks per second.

Top module: `interval_timer3`

## Requirements
- R1: After synchronous reset, every counter is idle in terminal-count mode with its output low. Each counter is set to low-then-high byte access with a zero count, so a read of any data port returns 0x00.
- R2: A write to offset 3 is decoded as follows. Bits 7-6 choose the counter (00, 01, 10). Bits 5-4 choose the access type. Bits 3-1 choose the mode. Bit 0 chooses BCD (1) or binary (0). A control word whose bits 7-6 are 11 changes no counter and no output.
- R3: Access code 01 loads only the low byte and 10 loads only the high byte; the other byte is zero in both cases. Code 11 takes the low byte first and then the high byte. A write flip-flop, cleared by each control word, toggles on each data write. The count is loaded only when the high byte arrives.
- R4: In terminal-count mode (mode code 000), the output goes low when the control word is written and stays low when a count is written. With count N loaded at clock edge E, the output goes high at edge E+N and then holds high until the counter is reprogrammed.
- R5: In rate-generator mode (mode bits 2-1 = 10), the output is low for exactly one clock per period, while the count equals 1. On the next edge the divisor reloads on its own, so the period is N clocks.
- R6: In square-wave mode (mode bits 2-1 = 11), the output is high for ceil(N/2) clocks and then low for floor(N/2) clocks of each N-clock period.
- R7: With bit 0 set, the counter steps down through packed BCD digits, so 0x0100 is followed by 0x0099. A loaded count of 0 stands for 10000 in BCD mode and for 65536 in binary mode.
- R8: Access code 00 captures the selected counter's value at the accepting edge while counting goes on. Reads return the captured value in the counter's byte order. The capture is released after its last byte has been read. A second capture command before release is ignored.
- R9: Without a capture, a data-port read returns the live count in the programmed byte order, and reading has no effect on counting.
- R10: Mode codes 110 and 111 behave as the rate generator and square wave. Codes 001, 100 and 101 behave as terminal-count mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common counting and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; advances the read byte order and releases captures |
| addr | input | 2 | Port offset: 0-2 counter data, 3 control word |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte of the addressed counter (combinational) |
| tmr_out | output | 3 | One output pin per counter |

## Verification
The bench goes after corner cases where a plausible implementation slips by one clock or one byte.

- Odd divisors in square-wave mode: a design that halves the count the wrong way gives the longer half to the low phase.
- Zero divisors: a design that forgets 0 means 65536 or 10000 produces an output that never fires, or fires at once.
- BCD steps across a digit boundary, such as 0x0100: a design that borrows like binary lands on 0x00FF and stretches the period.
- Snapshot reads: a design that reads the live count, releases the capture too early, or accepts a second capture returns a changed value.
- Split loads and control words with select 11: these catch a counter that starts early on a lone low byte, or one that is reprogrammed by an invalid select.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DIGITS = CNT_W / 4;
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        OP_TERMINAL = 2'd0,
        OP_RATE     = 2'd1,
        OP_SQUARE   = 2'd2
    } op_e;

    typedef struct packed {
        logic [1:0] sel;
        access_e    acc;
        logic [2:0] op;
        logic       bcd;
    } ctrl_t;

    // Only the two low mode bits matter; the top bit is a don't-care
    // for the periodic modes.
    function automatic op_e op_decode(input logic [2:0] code);
        case (code[1:0])
            2'b10:   return OP_RATE;
            2'b11:   return OP_SQUARE;
            default: return OP_TERMINAL;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic borrow;
        r = v;
        borrow = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                if (v[i*4 +: 4] == 4'd0) begin
                    r[i*4 +: 4] = 4'd9;
                end else begin
                    r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] bcd_half(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic [3:0] d;
        logic carry;
        r = '0;
        carry = 1'b0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            d = v[i*4 +: 4];
            r[i*4 +: 4] = {1'b0, d[3:1]} + (carry ? 4'd5 : 4'd0);
            carry = d[0];
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v,
                                                    input logic bcd);
        return bcd ? bcd_dec(v) : v - CNT_W'(1);
    endfunction

    // Boundary between the high and low phase of a square wave; a zero
    // divisor stands for the full range of the selected number system.
    function automatic logic [CNT_W-1:0] half_point(input logic [CNT_W-1:0] div,
                                                    input logic bcd);
        if (div == '0) begin
            return bcd ? {4'd5, {(CNT_W-4){1'b0}}} : {1'b1, {(CNT_W-1){1'b0}}};
        end
        return bcd ? bcd_half(div) : (div >> 1);
    endfunction

endpackage

// File: rtl/itmr_bus_decode.sv
module itmr_bus_decode
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [NUM_CH-1:0] ctrl_we,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re
);

    assign ctrl = ctrl_t'(wdata);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign ctrl_we[g] = wr_en && (addr == CTRL_ADDR) && (ctrl.sel == 2'(g));
        assign data_we[g] = wr_en && (addr == 2'(g));
        assign data_re[g] = rd_en && (addr == 2'(g));
    end

endmodule

// File: rtl/itmr_downcounter.sv
module itmr_downcounter
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             disarm,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  op_e              op,
    input  logic             bcd,
    output logic [CNT_W-1:0] cnt,
    output logic             out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_q;
    logic             armed_q;
    logic             tc_q;
    logic [CNT_W-1:0] half;

    assign cnt  = cnt_q;
    assign half = half_point(div_q, bcd);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            div_q   <= '0;
            armed_q <= 1'b0;
            tc_q    <= 1'b0;
        end else if (disarm) begin
            armed_q <= 1'b0;
            tc_q    <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            div_q   <= load_val;
            armed_q <= 1'b1;
            tc_q    <= 1'b0;
        end else if (armed_q) begin
            if (op == OP_TERMINAL) begin
                cnt_q <= count_step(cnt_q, bcd);
                if (cnt_q == CNT_W'(1)) begin
                    tc_q <= 1'b1;
                end
            end else begin
                cnt_q <= (cnt_q == CNT_W'(1)) ? div_q : count_step(cnt_q, bcd);
            end
        end
    end

    always_comb begin
        if (!armed_q) begin
            out = (op != OP_TERMINAL);
        end else begin
            case (op)
                OP_RATE:   out = (cnt_q != CNT_W'(1));
                OP_SQUARE: out = (cnt_q == '0) || (cnt_q > half);
                default:   out = tc_q;
            endcase
        end
    end

    // R4: once the terminal flag is up it stays up until reprogrammed
    p_terminal_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TERMINAL && out && !disarm && !load) |=> out);

    // R5: the rate pulse is exactly one clock wide
    p_rate_pulse_one_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RATE && armed_q && !out && !disarm && !load && div_q != CNT_W'(1))
        |=> out);

endmodule

// File: rtl/itmr_channel.sv
module itmr_channel
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  access_e           ctrl_acc,
    input  logic [2:0]        ctrl_op,
    input  logic              ctrl_bcd,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out
);

    access_e          acc_q;
    op_e              op_q;
    logic             bcd_q;
    logic             wr_hi_q;
    logic             rd_hi_q;
    logic             latched_q;
    logic [CNT_W-1:0] snap_q;
    logic [BYTE_W-1:0] lo_pend_q;

    logic             is_latch;
    logic             disarm;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] src;
    logic             hi_sel;

    assign is_latch = (ctrl_acc == ACC_LATCH);
    assign disarm   = ctrl_we && !is_latch;

    always_comb begin
        load     = 1'b0;
        load_val = '0;
        if (data_we) begin
            case (acc_q)
                ACC_LO: begin
                    load     = 1'b1;
                    load_val = {{(CNT_W-BYTE_W){1'b0}}, wdata};
                end
                ACC_HI: begin
                    load     = 1'b1;
                    load_val = {wdata, {(CNT_W-BYTE_W){1'b0}}};
                end
                default: begin
                    load     = wr_hi_q;
                    load_val = {wdata, lo_pend_q};
                end
            endcase
        end
    end

    assign src     = latched_q ? snap_q : cnt;
    assign hi_sel  = (acc_q == ACC_HI) || (acc_q == ACC_BOTH && rd_hi_q);
    assign rd_byte = hi_sel ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= ACC_BOTH;
            op_q      <= OP_TERMINAL;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            latched_q <= 1'b0;
            snap_q    <= '0;
            lo_pend_q <= '0;
        end else begin
            if (ctrl_we) begin
                if (is_latch) begin
                    if (!latched_q) begin
                        latched_q <= 1'b1;
                        snap_q    <= cnt;
                        rd_hi_q   <= 1'b0;
                    end
                end else begin
                    acc_q     <= ctrl_acc;
                    op_q      <= op_decode(ctrl_op);
                    bcd_q     <= ctrl_bcd;
                    wr_hi_q   <= 1'b0;
                    rd_hi_q   <= 1'b0;
                    latched_q <= 1'b0;
                end
            end
            if (data_we && acc_q == ACC_BOTH) begin
                if (!wr_hi_q) begin
                    lo_pend_q <= wdata;
                end
                wr_hi_q <= ~wr_hi_q;
            end
            if (data_re) begin
                if (acc_q == ACC_BOTH) begin
                    rd_hi_q <= ~rd_hi_q;
                end
                if (acc_q != ACC_BOTH || rd_hi_q) begin
                    latched_q <= 1'b0;
                end
            end
        end
    end

    itmr_downcounter i_core (
        .clk      (clk),
        .rst      (rst),
        .disarm   (disarm),
        .load     (load),
        .load_val (load_val),
        .op       (op_q),
        .bcd      (bcd_q),
        .cnt      (cnt),
        .out      (out)
    );

    // R8: a held snapshot does not move until it is read out or replaced
    p_snapshot_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (latched_q && !data_re && !disarm) |=> (latched_q && $stable(snap_q)));

endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
    import itmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CH-1:0] tmr_out
);

    ctrl_t             ctrl;
    logic [NUM_CH-1:0] ctrl_we;
    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] data_re;
    logic [BYTE_W-1:0] rd_byte [NUM_CH];

    itmr_bus_decode #(.NUM_CH(NUM_CH)) i_decode (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl    (ctrl),
        .ctrl_we (ctrl_we),
        .data_we (data_we),
        .data_re (data_re)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        itmr_channel i_channel (
            .clk      (clk),
            .rst      (rst),
            .ctrl_we  (ctrl_we[g]),
            .ctrl_acc (ctrl.acc),
            .ctrl_op  (ctrl.op),
            .ctrl_bcd (ctrl.bcd),
            .data_we  (data_we[g]),
            .data_re  (data_re[g]),
            .wdata    (wdata),
            .rd_byte  (rd_byte[g]),
            .out      (tmr_out[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) begin
                rdata = rd_byte[i];
            end
        end
    end

    // R2: a control word reaches at most one counter, none for select 11
    p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl_we));

    p_sel3_dropped_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CTRL_ADDR && wdata[7:6] == 2'b11) |-> (ctrl_we == '0));

endmodule

// File: tb/test_interval_timer3.sv
module test_interval_timer3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tmr_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    interval_timer3 i_interval_timer3 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .tmr_out (tmr_out)
    );

    // {control word, divisor, expected low clocks, expected high clocks}
    localparam logic [55:0] VEC [10] = '{
        {8'h34, 16'd6,    16'd1,  16'd5},
        {8'h36, 16'd7,    16'd3,  16'd4},
        {8'h36, 16'd8,    16'd4,  16'd4},
        {8'h3C, 16'd5,    16'd1,  16'd4},
        {8'h3E, 16'd9,    16'd4,  16'd5},
        {8'h36, 16'd3,    16'd1,  16'd2},
        {8'h37, 16'h0015, 16'd7,  16'd8},
        {8'h35, 16'h0012, 16'd1,  16'd11},
        {8'h37, 16'h0100, 16'd50, 16'd50},
        {8'h35, 16'h0000, 16'd1,  16'd9999}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // called at a falling edge, returns one clock later
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic measure(input int ch, output int lo, output int hi);
        int guard = 0;
        while (tmr_out[ch] !== 1'b0 && guard < 30000) begin
            @(negedge clk); guard++;
        end
        lo = 0;
        while (tmr_out[ch] === 1'b0 && lo < 30000) begin
            lo++; @(negedge clk);
        end
        hi = 0;
        while (tmr_out[ch] === 1'b1 && hi < 30000) begin
            hi++; @(negedge clk);
        end
    endtask

    // terminal-count timing: count loaded at the last write, output
    // rises exactly n clocks later
    task automatic tc_timing(input string req, input int ch, input int n);
        repeat (n - 1) @(negedge clk);
        chk(req, "terminal output one clock early", 32'(tmr_out[ch]), 0);
        @(negedge clk);
        chk(req, "terminal output at count end", 32'(tmr_out[ch]), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int lo, hi;
        string req;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "outputs after reset", 32'(tmr_out), 0);
        rd(2'd0, b);
        chk("R1", "data read after reset", 32'(b), 0);

        // vector table on counter 0: R5 R6 R7 R10
        for (int i = 0; i < 10; i++) begin
            logic [55:0] v;
            v = VEC[i];
            req = v[48] ? "R7" : (v[51] ? "R10" : (v[49] ? "R6" : "R5"));
            wr(2'd3, v[55:48]);
            wr(2'd0, v[39:32]);
            wr(2'd0, v[47:40]);
            measure(0, lo, hi);
            chk(req, $sformatf("vector %0d low clocks", i), 32'(lo), 32'(v[31:16]));
            chk(req, $sformatf("vector %0d high clocks", i), 32'(hi), 32'(v[15:0]));
        end

        // R4 terminal count, N = 5
        wr(2'd3, 8'h30);
        chk("R4", "output low after control word", 32'(tmr_out[0]), 0);
        wr(2'd0, 8'h05);
        chk("R4", "output low after low byte", 32'(tmr_out[0]), 0);
        wr(2'd0, 8'h00);
        tc_timing("R4", 0, 5);
        repeat (10) @(negedge clk);
        chk("R4", "output stays high", 32'(tmr_out[0]), 1);

        // R10 mode code 001 acts as terminal count
        wr(2'd3, 8'h32);
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h00);
        tc_timing("R10", 0, 3);
        repeat (5) @(negedge clk);
        chk("R10", "alias holds high", 32'(tmr_out[0]), 1);

        // R7 zero divisor: 65536 binary, 10000 BCD
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        tc_timing("R7", 0, 65536);
        wr(2'd3, 8'h31);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        tc_timing("R7", 0, 10000);

        // R3 byte access on counter 2
        wr(2'd3, 8'hB0);
        wr(2'd2, 8'h04);
        repeat (10) @(negedge clk);
        chk("R3", "no start after lone low byte", 32'(tmr_out[2]), 0);
        wr(2'd2, 8'h00);
        tc_timing("R3", 2, 4);
        wr(2'd3, 8'h90);
        wr(2'd2, 8'h07);
        tc_timing("R3", 2, 7);
        wr(2'd3, 8'hA0);
        wr(2'd2, 8'h01);
        tc_timing("R3", 2, 256);

        // R2 select 11 ignored
        wr(2'd3, 8'hF0);
        repeat (3) @(negedge clk);
        chk("R2", "counter 0 output after select 11", 32'(tmr_out[0]), 1);
        chk("R2", "counter 2 output after select 11", 32'(tmr_out[2]), 1);

        // R8 snapshot on counter 1, rate mode, divisor 1000
        wr(2'd3, 8'h74);
        wr(2'd1, 8'hE8);
        wr(2'd1, 8'h03);
        wr(2'd3, 8'h40);
        repeat (20) @(negedge clk);
        rd(2'd1, b);
        chk("R8", "snapshot low byte", 32'(b), 32'hE8);
        rd(2'd1, b);
        chk("R8", "snapshot high byte", 32'(b), 32'h03);
        rd(2'd1, b);
        chk("R8", "live low byte after release", 32'(b), 32'hD1);
        rd(2'd1, b);
        chk("R8", "live high byte after release", 32'(b), 32'h03);
        wr(2'd3, 8'h40);
        repeat (5) @(negedge clk);
        wr(2'd3, 8'h40);
        repeat (5) @(negedge clk);
        rd(2'd1, b);
        chk("R8", "second capture ignored, low", 32'(b), 32'hCF);
        rd(2'd1, b);
        chk("R8", "second capture ignored, high", 32'(b), 32'h03);

        // R9 live reads, low byte only, on counter 2
        wr(2'd3, 8'h94);
        wr(2'd2, 8'h40);
        rd(2'd2, b);
        chk("R9", "live count at load", 32'(b), 32'h40);
        repeat (3) @(negedge clk);
        rd(2'd2, b);
        chk("R9", "live count four clocks on", 32'(b), 32'h3C);
        rd(2'd2, b);
        chk("R9", "read does not disturb count", 32'(b), 32'h3B);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule